// File: doc/BRIEF.md
# ADC Multi-Channel Scan Sequencer

This block steps an analog-to-digital converter through a run of channel numbers. A start pulse loads a programmable first channel and raises the busy flag. The converter converts the channel on `chan_o` while `busy_o` is high and reports each finished conversion with a one-cycle `conv_done_i` pulse that carries a 10-bit sample. On each accepted pulse the block writes the sample into a result slot and moves to the next channel. The slot index is the conversion's position in the sequence. A sequence ends after `SEQ_LEN` conversions.

A control byte sets the scan behaviour. In multi-channel mode the channel counter returns to channel 0 after it converts a programmed last channel, called the wrap limit. In single-channel mode every conversion uses the first channel. The same byte selects whether each sample sits at the top or the bottom of the 16-bit result word. Any write to the control byte stops a running sequence at once. A wrap limit of 0 is not a valid setting. The block still handles it safely and records it in a sticky error flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `cfg_rdata_o` is 0x0F (wrap limit 15, single-channel mode, left placement), `busy_o` is 0, `chan_o` is 0, `cfg_err_o` is 0 and `res_wr_o` is 0.
- R2: Layout of the control byte: bits 3:0 hold the wrap limit, bit 4 selects multi-channel mode, bit 5 selects right placement, and bits 6 and 7 are reserved. A written byte reads back on `cfg_rdata_o` from the next cycle, with bits 7:6 always 0.
- R3: A cycle with `cfg_wr_i` high drops `busy_o` in the next cycle. A `conv_done_i` pulse or a start pulse in that same cycle has no effect.
- R4: When the block is idle, a start pulse loads `start_ch_i` into `chan_o`, restarts the slot count at 0 and raises `busy_o`, all in the next cycle. A start pulse while `busy_o` is high is ignored.
- R5: In multi-channel mode, an accepted done pulse on the wrap-limit channel makes the next channel 0. On any other channel the next channel is the current one plus 1.
- R6: If the first channel is above the wrap limit, the counter climbs to 15 and then continues at 0.
- R7: Writing a wrap limit of 0 sets `cfg_err_o`, which stays set until reset. With a limit of 0, multi-channel mode stays on channel 0.
- R8: In single-channel mode the channel does not change during a sequence.
- R9: One cycle after an accepted done pulse, `res_wr_o` is high for one cycle and `res_idx_o` gives the conversion order, starting at 0. After the `SEQ_LEN`-th conversion, `busy_o` drops and the channel stays where it is.
- R10: With left placement, `res_data_o` holds the sample in bits 15:6 and zeros below. With right placement it holds the sample in bits 9:0 and zeros above. The placement setting at the time of the done pulse decides.
- R11: A done pulse while idle produces no result write and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Control byte write strobe (also aborts) |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read value |
| cfg_err_o | output | 1 | Sticky flag: a wrap limit of 0 was written |
| start_i | input | 1 | Start pulse for a new sequence |
| start_ch_i | input | 4 | First channel of the sequence |
| conv_done_i | input | 1 | Converter conversion-finished pulse |
| conv_data_i | input | 10 | Sample delivered with the done pulse |
| chan_o | output | 4 | Channel to convert |
| busy_o | output | 1 | Sequence active |
| res_wr_o | output | 1 | Result write strobe |
| res_idx_o | output | 3 | Result slot (conversion order) |
| res_data_o | output | 16 | Placed result word |

## Verification
Every output of the block comes from a register. A write, a start pulse or a done pulse therefore shows its effect exactly one clock edge later: readback, error flag and busy after a write; channel and busy after a start; the result strobe, slot and placed word, and the next channel, after a done pulse. The bench drives inputs on the falling edge and advances a behavioural model of the requirements at the rising edge. It then compares every output with that model at the next falling edge. A one-cycle slip in any result is therefore reported at once.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W    = 4;
    localparam int SMP_W   = 10;
    localparam int WORD_W  = 16;
    localparam int PAD_W   = WORD_W - SMP_W;

    typedef struct packed {
        logic            right;
        logic            multi;
        logic [CH_W-1:0] wrap;
    } seq_cfg_t;

    localparam seq_cfg_t CFG_RESET = '{right: 1'b0, multi: 1'b0, wrap: '1};

    function automatic logic [CH_W-1:0] next_chan(input logic [CH_W-1:0] cur,
                                                  input logic [CH_W-1:0] lim);
        return (cur == lim) ? '0 : cur + 1'b1;
    endfunction

    function automatic logic [WORD_W-1:0] place(input logic [SMP_W-1:0] smp,
                                                input logic right);
        return right ? {{PAD_W{1'b0}}, smp} : {smp, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  logic [7:0] wdata,
    output seq_cfg_t cfg,
    output logic [7:0] rdata,
    output logic     err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
            err <= 1'b0;
        end else if (wr) begin
            cfg.wrap  <= wdata[CH_W-1:0];
            cfg.multi <= wdata[4];
            cfg.right <= wdata[5];
            if (wdata[CH_W-1:0] == '0) err <= 1'b1;
        end
    end

    assign rdata = {2'b00, cfg.right, cfg.multi, cfg.wrap};

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err |=> err); // R7
    AST_ZERO_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[3:0] == 4'd0) |=> err); // R7
endmodule

// File: rtl/adc_seq_counter.sv
module adc_seq_counter
    import adc_seq_pkg::*;
#(
    parameter int SEQ_LEN = 8,
    localparam int SLOT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              go,
    input  logic [CH_W-1:0]   start_ch,
    input  logic              done,
    input  seq_cfg_t          cfg,
    output logic [CH_W-1:0]   chan,
    output logic              busy,
    output logic              accept,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SEQ_LEN - 1);

    assign accept = busy && done && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan <= '0;
            busy <= 1'b0;
            slot <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (go && !busy) begin
            chan <= start_ch;
            busy <= 1'b1;
            slot <= '0;
        end else if (accept) begin
            if (slot == LAST) begin
                busy <= 1'b0;
            end else begin
                slot <= slot + 1'b1;
                if (cfg.multi) chan <= next_chan(chan, cfg.wrap);
            end
        end
    end

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst) abort |=> !busy); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (accept && cfg.multi && chan == cfg.wrap && slot != LAST) |=> chan == '0); // R5
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg.multi && !abort) |=> $stable(chan)); // R8
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (go && !busy && !abort) |=> (busy && chan == $past(start_ch))); // R4
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
    import adc_seq_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SMP_W-1:0]  smp,
    input  logic              right,
    output logic              res_wr,
    output logic [SLOT_W-1:0] res_idx,
    output logic [WORD_W-1:0] res_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_wr   <= 1'b0;
            res_idx  <= '0;
            res_data <= '0;
        end else begin
            res_wr <= accept;
            if (accept) begin
                res_idx  <= slot;
                res_data <= place(smp, right);
            end
        end
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        res_wr |-> $past(accept)); // R9
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int SEQ_LEN = 8,
    localparam int SLOT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    output logic              cfg_err_o,
    input  logic              start_i,
    input  logic [CH_W-1:0]   start_ch_i,
    input  logic              conv_done_i,
    input  logic [SMP_W-1:0]  conv_data_i,
    output logic [CH_W-1:0]   chan_o,
    output logic              busy_o,
    output logic              res_wr_o,
    output logic [SLOT_W-1:0] res_idx_o,
    output logic [WORD_W-1:0] res_data_o
);
    seq_cfg_t          cfg;
    logic              accept;
    logic [SLOT_W-1:0] slot;

    adc_seq_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr_i), .wdata(cfg_wdata_i),
        .cfg(cfg), .rdata(cfg_rdata_o), .err(cfg_err_o)
    );

    adc_seq_counter #(.SEQ_LEN(SEQ_LEN)) u_cnt (
        .clk(clk), .rst(rst), .abort(cfg_wr_i), .go(start_i),
        .start_ch(start_ch_i), .done(conv_done_i), .cfg(cfg),
        .chan(chan_o), .busy(busy_o), .accept(accept), .slot(slot)
    );

    adc_seq_result #(.SLOT_W(SLOT_W)) u_res (
        .clk(clk), .rst(rst), .accept(accept), .slot(slot),
        .smp(conv_data_i), .right(cfg.right),
        .res_wr(res_wr_o), .res_idx(res_idx_o), .res_data(res_data_o)
    );

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> !res_wr_o); // R11
    AST_ABORT_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i |=> !res_wr_o); // R3
endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
    localparam int L = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, go = 1'b0, done = 1'b0;
    logic [7:0]  wd = '0;
    logic [3:0]  sc = '0;
    logic [9:0]  dd = '0;
    logic [7:0]  rdata;
    logic        err, busy, rwr;
    logic [3:0]  chan;
    logic [2:0]  ridx;
    logic [15:0] rdat;

    int n_tests = 0, n_fail = 0;

    int m_wrap, m_mult, m_right, m_err, m_busy, m_chan, m_slot, m_rwr, m_ridx, m_rdat;

    always #5 clk = ~clk;

    adc_scan_seq #(.SEQ_LEN(L)) u0 (
        .clk(clk), .rst(rst), .cfg_wr_i(wr), .cfg_wdata_i(wd), .cfg_rdata_o(rdata),
        .cfg_err_o(err), .start_i(go), .start_ch_i(sc), .conv_done_i(done),
        .conv_data_i(dd), .chan_o(chan), .busy_o(busy), .res_wr_o(rwr),
        .res_idx_o(ridx), .res_data_o(rdat)
    );

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_wrap = 15; m_mult = 0; m_right = 0; m_err = 0;
        m_busy = 0; m_chan = 0; m_slot = 0; m_rwr = 0; m_ridx = 0; m_rdat = 0;
    endtask

    task automatic model_step();
        m_rwr = 0;
        if (wr) begin
            m_wrap = wd[3:0]; m_mult = wd[4]; m_right = wd[5];
            if (wd[3:0] == 0) m_err = 1;
            m_busy = 0;
        end else if (go && m_busy == 0) begin
            m_busy = 1; m_chan = sc; m_slot = 0;
        end else if (done && m_busy == 1) begin
            m_rwr = 1; m_ridx = m_slot;
            m_rdat = m_right ? int'(dd) : int'(dd) * 64;
            if (m_slot == L - 1) m_busy = 0;
            else begin
                m_slot++;
                if (m_mult == 1) m_chan = (m_chan == m_wrap) ? 0 : (m_chan + 1) % 16;
            end
        end
    endtask

    task automatic compare(input string req);
        chk(req, "cfg_rdata", int'(rdata), (m_right << 5) | (m_mult << 4) | m_wrap);
        chk(req, "cfg_err", int'(err), m_err);
        chk(req, "busy", int'(busy), m_busy);
        chk(req, "chan", int'(chan), m_chan);
        chk(req, "res_wr", int'(rwr), m_rwr);
        if (m_rwr == 1) begin
            chk(req, "res_idx", int'(ridx), m_ridx);
            chk(req, "res_data", int'(rdat), m_rdat);
        end
    endtask

    task automatic cyc(input string req, input logic w, input logic [7:0] d,
                       input logic g, input logic [3:0] s, input logic dn,
                       input logic [9:0] smp);
        wr = w; wd = d; go = g; sc = s; done = dn; dd = smp;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr = 0; go = 0; done = 0;
        compare(req);
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) cyc(req, 0, 8'h00, 0, 4'd0, 0, 10'd0);
    endtask

    task automatic convert(input string req, input int n, input logic [9:0] base);
        for (int i = 0; i < n; i++) begin
            cyc(req, 0, 8'h00, 0, 4'd0, 1, base + 10'(i * 37));
            idle(req, 1);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R1");

        // R2: reserved bits dropped on write
        cyc("R2", 1, 8'hC7, 0, 4'd0, 0, 10'd0);
        chk("R2", "rsvd bits", int'(rdata[7:6]), 0);

        // R11: done while idle
        cyc("R11", 0, 8'h00, 0, 4'd0, 1, 10'h155);
        chk("R11", "idle res_wr", int'(rwr), 0);

        // R5/R9/R10: multi wrap 3, left placement
        cyc("R2", 1, 8'h13, 0, 4'd0, 0, 10'd0);
        cyc("R4", 0, 8'h00, 1, 4'd0, 0, 10'd0);
        cyc("R4", 0, 8'h00, 1, 4'd9, 0, 10'd0);   // ignored, busy
        convert("R5", L, 10'h3FF);
        chk("R9", "seq end busy", int'(busy), 0);

        // R6: start above wrap, right placement
        cyc("R2", 1, 8'h33, 0, 4'd0, 0, 10'd0);
        cyc("R6", 0, 8'h00, 1, 4'd13, 0, 10'd0);
        convert("R6", L, 10'h201);

        // R10: back-to-back done pulses, left placement
        cyc("R10", 1, 8'h15, 0, 4'd0, 0, 10'd0);
        cyc("R10", 0, 8'h00, 1, 4'd2, 0, 10'd0);
        for (int i = 0; i < L; i++) cyc("R10", 0, 8'h00, 0, 4'd0, 1, 10'(i * 97 + 1));

        // R8: single-channel mode
        cyc("R8", 1, 8'h25, 0, 4'd0, 0, 10'd0);
        cyc("R8", 0, 8'h00, 1, 4'd6, 0, 10'd0);
        convert("R8", L, 10'h0AA);

        // R3: abort mid sequence with done in the same cycle
        cyc("R3", 1, 8'h17, 0, 4'd0, 0, 10'd0);
        cyc("R3", 0, 8'h00, 1, 4'd1, 0, 10'd0);
        convert("R3", 2, 10'h111);
        cyc("R3", 1, 8'h17, 1, 4'd4, 1, 10'h3C3);
        chk("R3", "abort busy", int'(busy), 0);
        idle("R3", 1);
        chk("R3", "abort res_wr", int'(rwr), 0);

        // R7: wrap limit 0
        chk("R7", "err before", int'(err), 0);
        cyc("R7", 1, 8'h10, 0, 4'd0, 0, 10'd0);
        cyc("R7", 0, 8'h00, 1, 4'd0, 0, 10'd0);
        convert("R7", 3, 10'h050);
        cyc("R7", 1, 8'h1F, 0, 4'd0, 0, 10'd0);
        chk("R7", "err sticky", int'(err), 1);
        idle("R7", 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule